// File: doc/BRIEF.md
# Ring-Buffer Stream Position Tracker

This block tracks one unidirectional byte stream that flows through a circular buffer in local memory. The hardware owns both buffer positions: the position on the hardware side moves by one byte for every data-side beat, and the position on the software side moves only when software writes a byte count to the commit register. Both positions wrap at the programmed buffer size. A fill counter holds the number of bytes between the two positions. Free space reads as size minus fill, so the used count is size minus free.

The direction is fixed at build time by `DIR_OUT`. With `DIR_OUT=1` the default, the stream runs out of memory. Software commits bytes it has written, and each beat consumes one byte. With `DIR_OUT=0` the stream runs into memory. Each beat fills one byte, and a commit releases bytes that software has read. With `PRELOAD=1` and the output direction, starting the stream treats the whole buffer as committed data. A segment pointer raises a sticky interrupt when the hardware position steps onto it. An arm command places that pointer `ARM_DIST` bytes ahead of the hardware position, modulo the size, so software can learn that the transfer has really begun.

Register words, indexed by `reg_addr`:
- 0: control. Bit 0 is enable, bit 1 is the arm command, bit 2 is the interrupt enable. On read, bit 1 returns busy.
- 1: status.
- 2: base.
- 3: size.
- 4: commit.
- 5: segment pointer.
- 6: read position.
- 7: write position.
- 8: free space.

Reads are combinational. Writes take effect at the next clock edge.

Top module: `ring_stream_tracker`

## Requirements
- R1: After reset, every register word reads 0, and `dat_ready`, `irq` and `buf_addr` are 0.
- R2: Writes to base and size force bits 6:0 to zero. These writes take effect only while the stream is stopped and are ignored while it runs or drains.
- R3: Writing enable=1 while stopped starts the stream only if the size is nonzero. With the default build, the start commits the whole buffer, so free space reads 0. Enable with size 0 is ignored.
- R4: While the stream runs, a commit of N bytes that fits moves the software position (write position for output) by N modulo size and lowers free space by N.
- R5: A commit larger than the free space is ignored, and it sets the sticky commit-error flag, status bit 2.
- R6: While running, `dat_ready` is high exactly when committed bytes remain. Each cycle with `dat_valid` and `dat_ready` high moves one byte and advances the hardware position (read position for output) by 1, wrapping to 0 at size. When the stream is not running, `dat_ready` is low and `dat_valid` has no effect.
- R7: While running, `dat_valid` high with `dat_ready` low sets the sticky underrun flag, status bit 1. For the input direction this flag reports overrun.
- R8: If the interrupt enable is set and a beat moves the hardware position onto the segment pointer, status bit 0 sets. `irq` equals status bit 0 AND the interrupt enable.
- R9: The arm command (control bit 1) loads the segment pointer with the hardware position plus 32, modulo size, and sets the interrupt enable.
- R10: Status bits clear when a 1 is written to them. If a flag's event falls in the same cycle as its clear, the flag stays set.
- R11: After enable is written to 0, the enable bit still reads 1 and `dat_ready` stays low for `DRAIN_CYC` cycles. Then enable reads 0, both positions read 0, and free space reads the full size.
- R12: Busy (control bit 1 on read) is 1 while draining, or while running with committed bytes left. Otherwise busy is 0.
- R13: `buf_addr` equals base plus the hardware position.
- R14: If a commit and a beat occur in the same cycle, both take effect. Free space changes by the beat minus the committed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data, combinational |
| dat_valid | input | 1 | Data-side request/valid for one byte |
| dat_ready | output | 1 | Block can move a byte this cycle |
| buf_addr | output | 32 | Memory address of the byte at the hardware position |
| irq | output | 1 | Segment-pointer interrupt |

## Verification
The hardest case is a software commit and a consumer beat in the same cycle. The commit check then sees the fill before that cycle's beat, and the fill counter must take both changes at once. The stimulus holds `dat_valid` high about 70% of the time and interleaves commits of random length, some just past the free space, plus status clears and re-arm commands. Coincidences therefore occur often. A bench model applies both changes in one step and compares free space, both positions, the status word and `irq` after every edge. It also checks that a flag raised in the same cycle as its clear survives.

// File: rtl/ring_stream_pkg.sv
package ring_stream_pkg;

    localparam int REG_W      = 32;
    localparam int ALIGN_BITS = 7;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_STAT   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_BASE   = 4'd2;
    localparam logic [ADDR_W-1:0] RA_SIZE   = 4'd3;
    localparam logic [ADDR_W-1:0] RA_COMMIT = 4'd4;
    localparam logic [ADDR_W-1:0] RA_SEG    = 4'd5;
    localparam logic [ADDR_W-1:0] RA_RDPOS  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_WRPOS  = 4'd7;
    localparam logic [ADDR_W-1:0] RA_FREE   = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } strm_st_e;

    // status word, bit 2 down to bit 0
    typedef struct packed {
        logic cerr;
        logic xrun;
        logic seg_hit;
    } evt_t;

    // control word, bit 2 down to bit 0
    typedef struct packed {
        logic ie;
        logic arm;
        logic en;
    } ctrl_bits_t;

    function automatic logic [REG_W-1:0] align_blk(input logic [REG_W-1:0] v);
        return {v[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import ring_stream_pkg::*;
#(
    parameter int DRAIN_CYC = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_wr,
    input  logic     en_val,
    input  logic     size_nz,
    output strm_st_e st,
    output logic     start,
    output logic     clr
);
    localparam int CNT_W = $clog2(DRAIN_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_comb start = (st == ST_IDLE) && en_wr && en_val && size_nz;
    always_comb clr   = (st == ST_IDLE) || ((st == ST_DRAIN) && (cnt == CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) st <= ST_RUN;
                end
                ST_RUN: begin
                    if (en_wr && !en_val) begin
                        st  <= ST_DRAIN;
                        cnt <= CNT_W'(DRAIN_CYC);
                    end
                end
                ST_DRAIN: begin
                    if (cnt == CNT_W'(1)) st <= ST_IDLE;
                    else                  cnt <= cnt - CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11: drain holds until its counter expires
    a_r11_drain_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && cnt != CNT_W'(1)) |=> (st == ST_DRAIN));
    // R11: a draining stream never resumes directly
    a_r11_no_resume: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN) |=> (st != ST_RUN));
    // R3: no start with a zero size
    a_r3_zero_size_idle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !size_nz) |=> (st == ST_IDLE));

endmodule

// File: rtl/rs_ptrs.sv
module rs_ptrs
    import ring_stream_pkg::*;
#(
    parameter int PTR_W    = 16,
    parameter bit DIR_OUT  = 1'b1,
    parameter bit PRELOAD  = 1'b1,
    parameter int ARM_DIST = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clr,
    input  logic             run,
    input  logic [PTR_W-1:0] size,
    input  logic             commit_wr,
    input  logic [REG_W-1:0] commit_len,
    input  logic             dat_valid,
    output logic [PTR_W-1:0] fill,
    output logic [PTR_W-1:0] hw_ptr,
    output logic [PTR_W-1:0] sw_ptr,
    output logic [PTR_W-1:0] hw_ptr_inc,
    output logic [PTR_W-1:0] arm_target,
    output logic             has_work,
    output logic             dat_ready,
    output logic             beat,
    output logic             commit_bad,
    output logic             starved
);
    localparam bit DO_PRELOAD = PRELOAD && DIR_OUT;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] d,
                                                  input logic [PTR_W-1:0] sz);
        logic [PTR_W:0] s;
        s = {1'b0, p} + {1'b0, d};
        if (s >= {1'b0, sz}) s = s - {1'b0, sz};
        return s[PTR_W-1:0];
    endfunction

    logic [PTR_W-1:0] avail;
    logic [PTR_W-1:0] add_len;
    logic [PTR_W-1:0] fill_nx;
    logic             len_ok;
    logic             commit_ok;

    generate
        if (DIR_OUT) begin : g_out
            assign avail    = size - fill;
            assign has_work = (fill != '0);
            assign fill_nx  = fill + add_len - PTR_W'(beat);
        end else begin : g_in
            assign avail    = fill;
            assign has_work = (fill != size);
            assign fill_nx  = fill - add_len + PTR_W'(beat);
        end
    endgenerate

    assign len_ok     = (commit_len <= REG_W'(avail));
    assign commit_ok  = run && commit_wr && len_ok;
    assign commit_bad = run && commit_wr && !len_ok;
    assign add_len    = commit_ok ? commit_len[PTR_W-1:0] : '0;
    assign dat_ready  = run && has_work;
    assign beat       = dat_ready && dat_valid;
    assign starved    = run && dat_valid && !has_work;
    assign hw_ptr_inc = wrap_add(hw_ptr, PTR_W'(1), size);
    assign arm_target = wrap_add(hw_ptr, PTR_W'(ARM_DIST), size);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            hw_ptr <= '0;
            sw_ptr <= '0;
        end else if (start) begin
            fill   <= DO_PRELOAD ? size : '0;
            hw_ptr <= '0;
            sw_ptr <= '0;
        end else if (clr) begin
            fill   <= '0;
            hw_ptr <= '0;
            sw_ptr <= '0;
        end else if (run) begin
            fill <= fill_nx;
            if (beat)      hw_ptr <= hw_ptr_inc;
            if (commit_ok) sw_ptr <= wrap_add(sw_ptr, add_len, size);
        end
    end

    // R6: fill never passes the buffer size
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (fill <= size));
    // R6: the hardware position only moves on a beat
    a_r6_hw_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !beat) |=> $stable(hw_ptr));
    // R5: a rejected commit leaves the software position alone
    a_r5_bad_commit_hold: assert property (@(posedge clk) disable iff (rst)
        commit_bad |=> $stable(sw_ptr));
    // R11: a stopped stream holds all counters at zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (clr && !start) |=> (fill == '0 && hw_ptr == '0 && sw_ptr == '0));

endmodule

// File: rtl/rs_flags.sv
module rs_flags
    import ring_stream_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_wr,
    input  logic [PTR_W-1:0] seg_val,
    input  logic             ctrl_wr,
    input  ctrl_bits_t       ctrl_val,
    input  logic [PTR_W-1:0] arm_target,
    input  logic             beat,
    input  logic [PTR_W-1:0] hw_ptr_inc,
    input  logic             starved,
    input  logic             commit_bad,
    input  logic             stat_wr,
    input  evt_t             stat_clr,
    output logic [PTR_W-1:0] seg_ptr,
    output logic             ie,
    output evt_t             status,
    output logic             irq
);
    evt_t set_v;
    evt_t clr_v;
    logic arm;

    assign arm           = ctrl_wr && ctrl_val.arm;
    assign set_v.seg_hit = beat && ie && (hw_ptr_inc == seg_ptr);
    assign set_v.xrun    = starved;
    assign set_v.cerr    = commit_bad;
    assign clr_v         = stat_wr ? stat_clr : '0;
    assign irq           = status.seg_hit && ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_ptr <= '0;
            ie      <= 1'b0;
            status  <= '0;
        end else begin
            if (arm)         seg_ptr <= arm_target;
            else if (seg_wr) seg_ptr <= seg_val;
            if (ctrl_wr)     ie <= ctrl_val.ie || ctrl_val.arm;
            status <= (status & ~clr_v) | set_v;
        end
    end

    // R10: a segment hit survives unless cleared
    a_r10_hit_sticky: assert property (@(posedge clk) disable iff (rst)
        (status.seg_hit && !(stat_wr && stat_clr.seg_hit)) |=> status.seg_hit);
    // R7: data request without data raises the xrun flag
    a_r7_xrun_set: assert property (@(posedge clk) disable iff (rst)
        starved |=> status.xrun);
    // R5: rejected commit raises the error flag
    a_r5_cerr_set: assert property (@(posedge clk) disable iff (rst)
        commit_bad |=> status.cerr);
    // R9: arming always enables the interrupt
    a_r9_arm_enables: assert property (@(posedge clk) disable iff (rst)
        arm |=> ie);

endmodule

// File: rtl/ring_stream_tracker.sv
module ring_stream_tracker
    import ring_stream_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter bit DIR_OUT   = 1'b1,
    parameter bit PRELOAD   = 1'b1,
    parameter int ARM_DIST  = 32,
    parameter int DRAIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dat_valid,
    output logic              dat_ready,
    output logic [REG_W-1:0]  buf_addr,
    output logic              irq
);
    strm_st_e         st;
    logic             start, clr, run;
    logic [REG_W-1:0] base_q;
    logic [PTR_W-1:0] size_q;
    logic [PTR_W-1:0] fill, hw_ptr, sw_ptr, hw_ptr_inc, arm_target, seg_ptr;
    logic [PTR_W-1:0] rd_pos, wr_pos;
    logic             has_work, beat, commit_bad, starved, ie, busy, en_rb;
    logic             wr_ctrl;
    ctrl_bits_t       cw;
    evt_t             status;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign cw      = ctrl_bits_t'(reg_wdata[2:0]);
    assign run     = (st == ST_RUN);
    assign en_rb   = (st != ST_IDLE);
    assign busy    = (st == ST_DRAIN) || (run && has_work);
    assign rd_pos  = DIR_OUT ? hw_ptr : sw_ptr;
    assign wr_pos  = DIR_OUT ? sw_ptr : hw_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            size_q <= '0;
        end else if (st == ST_IDLE && reg_we) begin
            if (reg_addr == RA_BASE) base_q <= align_blk(reg_wdata);
            if (reg_addr == RA_SIZE) size_q <= {reg_wdata[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    rs_ctrl #(.DRAIN_CYC(DRAIN_CYC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (wr_ctrl),
        .en_val  (cw.en),
        .size_nz (|size_q),
        .st      (st),
        .start   (start),
        .clr     (clr)
    );

    rs_ptrs #(
        .PTR_W    (PTR_W),
        .DIR_OUT  (DIR_OUT),
        .PRELOAD  (PRELOAD),
        .ARM_DIST (ARM_DIST)
    ) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .clr        (clr),
        .run        (run),
        .size       (size_q),
        .commit_wr  (reg_we && (reg_addr == RA_COMMIT)),
        .commit_len (reg_wdata),
        .dat_valid  (dat_valid),
        .fill       (fill),
        .hw_ptr     (hw_ptr),
        .sw_ptr     (sw_ptr),
        .hw_ptr_inc (hw_ptr_inc),
        .arm_target (arm_target),
        .has_work   (has_work),
        .dat_ready  (dat_ready),
        .beat       (beat),
        .commit_bad (commit_bad),
        .starved    (starved)
    );

    rs_flags #(.PTR_W(PTR_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .seg_wr     (reg_we && (reg_addr == RA_SEG)),
        .seg_val    (reg_wdata[PTR_W-1:0]),
        .ctrl_wr    (wr_ctrl),
        .ctrl_val   (cw),
        .arm_target (arm_target),
        .beat       (beat),
        .hw_ptr_inc (hw_ptr_inc),
        .starved    (starved),
        .commit_bad (commit_bad),
        .stat_wr    (reg_we && (reg_addr == RA_STAT)),
        .stat_clr   (evt_t'(reg_wdata[2:0])),
        .seg_ptr    (seg_ptr),
        .ie         (ie),
        .status     (status),
        .irq        (irq)
    );

    assign buf_addr = base_q + REG_W'(hw_ptr);

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = REG_W'({ie, busy, en_rb});
            RA_STAT:  reg_rdata = REG_W'(status);
            RA_BASE:  reg_rdata = base_q;
            RA_SIZE:  reg_rdata = REG_W'(size_q);
            RA_SEG:   reg_rdata = REG_W'(seg_ptr);
            RA_RDPOS: reg_rdata = REG_W'(rd_pos);
            RA_WRPOS: reg_rdata = REG_W'(wr_pos);
            RA_FREE:  reg_rdata = REG_W'(size_q - fill);
            default:  reg_rdata = '0;
        endcase
    end

    // R13: address output follows the hardware position on a beat
    a_r13_addr_step: assert property (@(posedge clk) disable iff (rst)
        (beat && hw_ptr_inc != '0) |=> (buf_addr == $past(buf_addr) + 1));
    // R11: no data moves while draining
    a_r11_drain_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN) |-> !dat_ready);

endmodule

// File: tb/ring_stream_tracker_bench.sv
module ring_stream_tracker_bench;
    import ring_stream_pkg::*;

    localparam int DR = 4;
    localparam int AD = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [31:0] buf_addr;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_size, m_fill, m_hw, m_sw, m_seg;
    bit m_ie;
    logic [2:0]  m_stat;
    logic [31:0] m_base;

    always #4 clk = ~clk;

    ring_stream_tracker #(.PTR_W(16), .DIR_OUT(1'b1), .PRELOAD(1'b1),
                          .ARM_DIST(AD), .DRAIN_CYC(DR)) u_ring_stream_tracker (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .dat_valid(dat_valid),
        .dat_ready(dat_ready), .buf_addr(buf_addr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_we   = 1'b0;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic int wrap(input int p, input int d, input int sz);
        return (p + d) % sz;
    endfunction

    // kind: 0 none, 1 commit, 2 status clear, 3 re-arm
    task automatic run_cyc(input bit v, input int kind, input logic [31:0] wd);
        bit   exp_ready, bt, ok, hit, xr, ce;
        int   nxt_hw;
        logic [31:0] d;
        string tg;
        exp_ready = (m_fill != 0);
        chk("R6 ready", {31'b0, dat_ready}, {31'b0, exp_ready});
        bt     = v && exp_ready;
        ok     = (kind == 1) && (int'(wd) <= m_size - m_fill);
        nxt_hw = bt ? wrap(m_hw, 1, m_size) : m_hw;
        hit    = bt && m_ie && (nxt_hw == m_seg);
        xr     = v && !exp_ready;
        ce     = (kind == 1) && !ok;
        m_stat = (m_stat & ~((kind == 2) ? wd[2:0] : 3'b000)) | {ce, xr, hit};
        if (kind == 3) begin
            m_seg = wrap(m_hw, AD, m_size);
            m_ie  = 1;
        end
        if (ok) begin
            m_fill = m_fill + int'(wd);
            m_sw   = wrap(m_sw, int'(wd), m_size);
        end
        if (bt) m_fill = m_fill - 1;
        m_hw = nxt_hw;
        tg = (ok && bt) ? "R14" : "R4";

        dat_valid = v;
        reg_we    = (kind != 0);
        reg_addr  = (kind == 1) ? RA_COMMIT : (kind == 2) ? RA_STAT : RA_CTRL;
        reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
        dat_valid = 1'b0;

        rd(RA_RDPOS, d); chk("R6 hw position", d, m_hw);
        rd(RA_WRPOS, d); chk("R4 sw position", d, m_sw);
        rd(RA_FREE, d);  chk({tg, " free"}, d, m_size - m_fill);
        rd(RA_STAT, d);  chk("R10 status (R5/R7/R8)", d, {29'b0, m_stat});
        rd(RA_SEG, d);   chk("R9 segment pointer", d, m_seg);
        chk("R8 irq", {31'b0, irq}, {31'b0, m_stat[0] & m_ie});
        chk("R13 buf_addr", buf_addr, m_base + m_hw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned sd;
        sd = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(RA_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(RA_STAT, d);  chk("R1 status", d, 0);
        rd(RA_SIZE, d);  chk("R1 size", d, 0);
        rd(RA_RDPOS, d); chk("R1 rdpos", d, 0);
        rd(RA_FREE, d);  chk("R1 free", d, 0);
        chk("R1 ready", {31'b0, dat_ready}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 buf_addr", buf_addr, 0);

        // R3 enable with zero size is ignored
        wr(RA_CTRL, 32'h1);
        rd(RA_CTRL, d); chk("R3 zero-size enable", d, 0);

        // R2 alignment
        wr(RA_SIZE, 32'h1FF);
        rd(RA_SIZE, d); chk("R2 size aligned", d, 32'h180);
        wr(RA_BASE, 32'h1234_5677);
        rd(RA_BASE, d); chk("R2 base aligned", d, 32'h1234_5600);

        // R6/R7 valid while stopped has no effect
        dat_valid = 1'b1;
        chk("R6 ready idle", {31'b0, dat_ready}, 0);
        @(posedge clk); @(negedge clk);
        dat_valid = 1'b0;
        rd(RA_STAT, d); chk("R7 idle valid ignored", d, 0);

        // R3 start with preload, R12 busy
        wr(RA_CTRL, 32'h1);
        rd(RA_CTRL, d); chk("R3/R12 ctrl after start", d, 32'h3);
        rd(RA_FREE, d); chk("R3 preload free", d, 0);
        chk("R6 ready after start", {31'b0, dat_ready}, 1);

        // R2 size locked while running
        wr(RA_SIZE, 32'h300);
        rd(RA_SIZE, d); chk("R2 size locked", d, 32'h180);

        // R5 oversize commit
        wr(RA_COMMIT, 32'h1);
        rd(RA_STAT, d);  chk("R5 commit error", d, 32'h4);
        rd(RA_WRPOS, d); chk("R5 position unchanged", d, 0);

        // R10 clear on write
        wr(RA_STAT, 32'h4);
        rd(RA_STAT, d); chk("R10 cleared", d, 0);

        // R9 arm
        wr(RA_CTRL, 32'h3);
        rd(RA_SEG, d);  chk("R9 armed pointer", d, 32);
        rd(RA_CTRL, d); chk("R9 ie set", d, 32'h7);

        m_size = 384; m_fill = 384; m_hw = 0; m_sw = 0; m_seg = 32;
        m_ie = 1; m_stat = 3'b000; m_base = 32'h1234_5600;

        // drain to empty, then underrun
        for (int i = 0; i < 420; i++) run_cyc(1'b1, 0, 32'h0);
        rd(RA_CTRL, d); chk("R12 idle-running not busy", d, 32'h5);

        // random mix
        for (int i = 0; i < 2500; i++) begin
            bit v;
            int r;
            v = ($urandom_range(0, 99) < 70);
            r = $urandom_range(0, 99);
            if (r < 8)       run_cyc(v, 1, 32'($urandom_range(0, (m_size - m_fill) + 6)));
            else if (r < 14) run_cyc(v, 2, 32'($urandom_range(0, 7)));
            else if (r < 16) run_cyc(v, 3, 32'h3);
            else             run_cyc(v, 0, 32'h0);
        end

        // R11 drain behaviour
        wr(RA_CTRL, 32'h4);
        rd(RA_CTRL, d); chk("R11/R12 draining", d, 32'h7);
        chk("R11 ready low in drain", {31'b0, dat_ready}, 0);
        for (int i = 0; i < DR - 1; i++) begin
            @(posedge clk); @(negedge clk);
        end
        rd(RA_CTRL, d); chk("R11 still draining", d, 32'h7);
        @(posedge clk); @(negedge clk);
        rd(RA_CTRL, d);  chk("R11 stopped", d, 32'h4);
        rd(RA_RDPOS, d); chk("R11 rdpos zero", d, 0);
        rd(RA_WRPOS, d); chk("R11 wrpos zero", d, 0);
        rd(RA_FREE, d);  chk("R11 free full", d, 384);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule